// File: doc/BRIEF.md
# Two-Stage Rotating Priority Interrupt Arbiter

This block chooses a single winner among 32 interrupt request lines. It works like a tournament. Six group arbiters each pick one request from their own slice of the sources. A final arbiter then picks one of the six group winners. The block presents the chosen source as a one-hot grant vector, together with its binary index and a valid flag. All of these are combinational from the current requests and the stored priority state.

Each of the seven arbiters has six inputs, numbered slot 0 to slot 5. Slot 0 always ranks first and slot 5 always ranks last. Slots 1 to 4 form a rotating ring, and a two-bit order select says which of them ranks highest. The control word arrives on a port. It carries one order select and one rotation enable for each arbiter.

When software pulses `serviced`, every arbiter that has rotation enabled moves its current ring winner to the bottom of the ring. This applies to the group arbiter that owns the granted source and to the final arbiter. Any change in the control word reloads every order select from the word.

Top module: `irq_tourney_arb`

## Requirements
- R1: With no request active, `grant` is all zero, `grant_idx` is 0 and `grant_valid` is low. After reset every arbiter's order select is 00.
- R2: Sources 0 to 3 occupy slots 1 to 4 of group 0. A source s of 4 or above occupies group 1+(s-4)/6, slot (s-4)%6. A lone request on any source grants exactly that source, with `grant_idx` = s.
- R3: `grant` has at most one bit set. That bit is always a requested bit, and its position equals `grant_idx` whenever `grant_valid` is high.
- R4: In a six-slot arbiter, select 00 ranks slots 0,1,2,3,4,5 from highest to lowest. Select 01 ranks 0,2,3,4,1,5. Select 10 ranks 0,3,4,1,2,5. Select 11 ranks 0,4,1,2,3,5.
- R5: Group 0 uses only slots 1 to 4, with the same ring order as R4. With select 00, requests on sources 0 and 2 together grant source 0.
- R6: The final arbiter ranks group winners by group number used as its slot number, following R4. The order select of arbiter n sits in control bits [2n+8:2n+7], so the final arbiter uses [20:19]. The rotation enable of arbiter n is bit n.
- R7: A `serviced` pulse while a grant is valid works as follows. In each affected arbiter (the owning group and the final one) with its rotation bit set, if the winning slot m is in 1..4, the select becomes m mod 4 from the next cycle on.
- R8: Servicing a winner in slot 0 or slot 5 leaves that arbiter's order unchanged.
- R9: With an arbiter's rotation bit clear, `serviced` has no effect on its order.
- R10: A cycle in which the control word differs from its value in the previous cycle reloads all seven selects from the word. This overrides a `serviced` pulse in the same cycle.
- R11: The grant reflects request changes in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 32 | Request lines, one per source |
| serviced | input | 1 | One-cycle pulse: the current grant has been handled |
| prio_ctrl | input | 21 | Rotation enables [6:0], order selects [20:7] |
| grant | output | 32 | One-hot granted source |
| grant_idx | output | 5 | Index of the granted source |
| grant_valid | output | 1 | High when any request is active |

## Verification
The interesting collision is a `serviced` pulse landing in the same cycle as a change of the control word. Rotation and reload then both want to write the same order state. The bench forces this in a directed step: servicing slot 1 of group 1 would move slot 2 to the top, while the new control word keeps that group's select at 00. The bench judges the result by the next cycle's grant, which must still be slot 1. A long pseudo-random run mixes sparse requests, frequent service pulses and occasional control rewrites against an arithmetic model. That run also covers a single pulse rotating a group arbiter and the final arbiter in the same edge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   localparam int SLOT_N  = 6;
   localparam int SMALL_N = 4;

   typedef logic [SLOT_N-1:0] slot_vec_t;

   // source number held by a group slot
   function automatic int src_of(input int grp, input int slot);
      if (grp == 0) return slot - 1;
      return SMALL_N + (grp - 1) * SLOT_N + slot;
   endfunction

   // whether a group slot is wired to a real source
   function automatic bit slot_used(input int grp, input int slot, input int nsrc);
      if (grp == 0 && (slot == 0 || slot == SLOT_N - 1)) return 1'b0;
      return src_of(grp, slot) < nsrc;
   endfunction

endpackage

// File: rtl/irq_rot_arb.sv
module irq_rot_arb
   import irq_arb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  slot_vec_t  req,
   input  logic [1:0] cfg_sel,
   input  logic       rot_en,
   input  logic       reload,
   input  logic       advance,
   output logic [2:0] win_idx,
   output logic       win_vld
);

   logic [1:0] sel_q;
   logic [2:0] pos;
   logic       middle;

   always_comb begin
      win_idx = '0;
      win_vld = 1'b0;
      pos     = '0;
      if (req[0]) begin
         win_vld = 1'b1;
      end else begin
         for (int k = 0; k < 4; k++) begin
            pos = 3'd1 + {1'b0, sel_q + 2'(k)};
            if (!win_vld && req[pos]) begin
               win_idx = pos;
               win_vld = 1'b1;
            end
         end
         if (!win_vld && req[SLOT_N-1]) begin
            win_idx = 3'(SLOT_N - 1);
            win_vld = 1'b1;
         end
      end
   end

   assign middle = win_vld && (win_idx != 3'd0) && (win_idx != 3'(SLOT_N - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        sel_q <= '0;
      else if (reload)                   sel_q <= cfg_sel;
      else if (advance && rot_en && middle) sel_q <= win_idx[1:0];
   end

   // R8
   ends_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && advance && win_vld && !middle) |=> $stable(sel_q));

   // R9
   rot_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && !rot_en) |=> $stable(sel_q));

   // R10
   reload_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (sel_q == $past(cfg_sel)));

endmodule

// File: rtl/irq_src_decode.sv
module irq_src_decode
   import irq_arb_pkg::*;
#(
   parameter int NUM_SRC = 32
) (
   input  logic                       vld,
   input  logic [2:0]                 grp,
   input  logic [2:0]                 slot,
   output logic [NUM_SRC-1:0]         onehot,
   output logic [$clog2(NUM_SRC)-1:0] idx
);

   localparam int IDX_W = $clog2(NUM_SRC);

   always_comb begin
      onehot = '0;
      idx    = '0;
      if (vld) begin
         idx         = IDX_W'(src_of(int'(grp), int'(slot)));
         onehot[idx] = 1'b1;
      end
   end

endmodule

// File: rtl/irq_tourney_arb.sv
module irq_tourney_arb
   import irq_arb_pkg::*;
#(
   parameter int NUM_SRC    = 32,
   parameter int GRP_CNT    = 6,
   parameter int CTRL_RESET = 'h7F
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SRC-1:0]         req,
   input  logic                       serviced,
   input  logic [3*(GRP_CNT+1)-1:0]   prio_ctrl,
   output logic [NUM_SRC-1:0]         grant,
   output logic [$clog2(NUM_SRC)-1:0] grant_idx,
   output logic                       grant_valid
);

   localparam int ARB_CNT = GRP_CNT + 1;
   localparam int CTRL_W  = 3 * ARB_CNT;
   localparam int CAP     = SMALL_N + (GRP_CNT - 1) * SLOT_N;

   generate
      if (GRP_CNT != SLOT_N) begin : g_bad_grp
         $error("final arbiter needs exactly %0d groups", SLOT_N);
      end
      if (NUM_SRC > CAP || NUM_SRC <= CAP - SLOT_N) begin : g_bad_src
         $error("NUM_SRC must fill the last group");
      end
   endgenerate

   slot_vec_t           grp_req [GRP_CNT];
   logic [2:0]          grp_idx [GRP_CNT];
   logic [GRP_CNT-1:0]  fin_req;
   logic [2:0]          fin_idx;
   logic                fin_vld;
   logic [2:0]          win_slot;
   logic [CTRL_W-1:0]   ctrl_q;
   logic                reload;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= CTRL_W'(CTRL_RESET);
      else        ctrl_q <= prio_ctrl;
   end

   assign reload = (prio_ctrl != ctrl_q);

   for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
      for (genvar i = 0; i < SLOT_N; i++) begin : g_slot
         if (slot_used(g, i, NUM_SRC)) begin : g_wire
            assign grp_req[g][i] = req[src_of(g, i)];
         end else begin : g_tie
            assign grp_req[g][i] = 1'b0;
         end
      end

      irq_rot_arb u_grp (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (grp_req[g]),
         .cfg_sel (prio_ctrl[ARB_CNT+2*g+1 -: 2]),
         .rot_en  (prio_ctrl[g]),
         .reload  (reload),
         .advance (serviced && fin_vld && (fin_idx == 3'(g))),
         .win_idx (grp_idx[g]),
         .win_vld (fin_req[g])
      );
   end

   irq_rot_arb u_fin (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (fin_req),
      .cfg_sel (prio_ctrl[CTRL_W-1 -: 2]),
      .rot_en  (prio_ctrl[GRP_CNT]),
      .reload  (reload),
      .advance (serviced),
      .win_idx (fin_idx),
      .win_vld (fin_vld)
   );

   always_comb begin
      win_slot = '0;
      for (int g = 0; g < GRP_CNT; g++)
         if (fin_idx == 3'(g)) win_slot = grp_idx[g];
   end

   irq_src_decode #(.NUM_SRC(NUM_SRC)) u_dec (
      .vld    (fin_vld),
      .grp    (fin_idx),
      .slot   (win_slot),
      .onehot (grant),
      .idx    (grant_idx)
   );

   assign grant_valid = fin_vld;

   // R3
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R3
   grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0);

   // R3
   idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> grant[grant_idx]);

   // R1
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |-> (!grant_valid && grant == '0));

   // R2
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (grant_valid && $countones(grant) == 1));

endmodule

// File: tb/test_irq_tourney_arb.sv
module test_irq_tourney_arb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] req;
   logic        serviced;
   logic [20:0] ctrl;
   logic [31:0] grant;
   logic [4:0]  grant_idx;
   logic        grant_valid;

   int checks = 0;
   int failures = 0;
   int m_sel [7];
   logic [20:0] m_prev;
   int e_w [6];
   int e_g;
   int e_src;
   logic [31:0] rs = 32'h1badf00d;

   always #2 clk = ~clk;

   irq_tourney_arb i_irq_tourney_arb (
      .clk(clk), .rst_n(rst_n), .req(req), .serviced(serviced),
      .prio_ctrl(ctrl), .grant(grant), .grant_idx(grant_idx),
      .grant_valid(grant_valid)
   );

   function automatic int grp_of(input int s);
      return (s < 4) ? 0 : 1 + (s - 4) / 6;
   endfunction

   function automatic int slot_of(input int s);
      return (s < 4) ? s + 1 : (s - 4) % 6;
   endfunction

   function automatic int pick6(input logic [5:0] r, input int sel);
      int ord [6];
      ord[0] = 0;
      for (int k = 0; k < 4; k++) ord[1+k] = 1 + ((sel + k) % 4);
      ord[5] = 5;
      for (int i = 0; i < 6; i++) if (r[ord[i]]) return ord[i];
      return -1;
   endfunction

   task automatic model_eval();
      logic [5:0] gv [6];
      logic [5:0] fv;
      for (int g = 0; g < 6; g++) gv[g] = '0;
      for (int s = 0; s < 32; s++) if (req[s]) gv[grp_of(s)][slot_of(s)] = 1'b1;
      for (int g = 0; g < 6; g++) begin
         e_w[g] = pick6(gv[g], m_sel[g]);
         fv[g]  = (e_w[g] >= 0);
      end
      e_g = pick6(fv, m_sel[6]);
      if (e_g < 0)       e_src = -1;
      else if (e_g == 0) e_src = e_w[0] - 1;
      else               e_src = 4 + (e_g - 1) * 6 + e_w[e_g];
   endtask

   task automatic check_out(input string tag);
      logic [31:0] xg;
      int xi;
      logic xv;
      xg = (e_src < 0) ? 32'h0 : (32'h1 << e_src);
      xi = (e_src < 0) ? 0 : e_src;
      xv = (e_src >= 0);
      checks++;
      if (grant !== xg || grant_idx !== 5'(xi) || grant_valid !== xv) begin
         failures++;
         $display("FAIL %s: grant=%h idx=%0d vld=%0b expected grant=%h idx=%0d vld=%0b",
                  tag, grant, grant_idx, grant_valid, xg, xi, xv);
      end
   endtask

   task automatic commit();
      if (ctrl != m_prev) begin
         for (int n = 0; n < 7; n++) m_sel[n] = int'(ctrl[2*n+8 -: 2]);
      end else if (serviced && e_g >= 0) begin
         if (ctrl[6] && e_g >= 1 && e_g <= 4) m_sel[6] = e_g % 4;
         if (ctrl[e_g] && e_w[e_g] >= 1 && e_w[e_g] <= 4) m_sel[e_g] = e_w[e_g] % 4;
      end
      m_prev = ctrl;
   endtask

   task automatic step(input logic [31:0] r, input logic sv, input logic [20:0] c,
                       input string tag);
      @(negedge clk);
      req = r; serviced = sv; ctrl = c;
      #1;
      model_eval();
      check_out(tag);
      commit();
   endtask

   task automatic expect_src(input int s, input string tag);
      checks++;
      if (!grant_valid || grant_idx !== 5'(s) || grant !== (32'h1 << s)) begin
         failures++;
         $display("FAIL %s: idx=%0d vld=%0b expected idx=%0d vld=1",
                  tag, grant_idx, grant_valid, s);
      end
   endtask

   task automatic zero_sel(input logic [20:0] c);
      step(32'h0, 1'b0, c ^ 21'h1, "R1 reload");
      step(32'h0, 1'b0, c, "R1 reload");
   endtask

   initial begin
      #(200000 * 4);
      failures++;
      $display("FAIL watchdog: expired expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [20:0] c;
      rst_n = 1'b0; req = '0; serviced = 1'b0; ctrl = 21'h7F;
      for (int n = 0; n < 7; n++) m_sel[n] = 0;
      m_prev = 21'h7F;
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (grant !== 32'h0 || grant_idx !== 5'd0 || grant_valid !== 1'b0) begin
         failures++;
         $display("FAIL R1: grant=%h idx=%0d vld=%0b expected grant=0 idx=0 vld=0",
                  grant, grant_idx, grant_valid);
      end
      rst_n = 1'b1;
      step(32'h0, 1'b0, 21'h7F, "R1");

      // R2 R3: every lone source
      for (int s = 0; s < 32; s++) begin
         step(32'h1 << s, 1'b0, 21'h7F, "R2 R3");
         expect_src(s, "R2");
      end

      // R5: default order, sources 0 and 2
      step(32'h5, 1'b0, 21'h7F, "R5");
      expect_src(0, "R5");
      for (int k = 0; k < 4; k++)
         for (int p = 1; p < 16; p++) step(32'(p), 1'b0, 21'(k) << 7, "R5");

      // R4: six-slot group 1 under each order select
      for (int k = 0; k < 4; k++)
         for (int p = 1; p < 64; p++) step(32'(p) << 4, 1'b0, 21'(k) << 9, "R4");

      // R6: final arbiter over group representatives
      for (int k = 0; k < 4; k++)
         for (int p = 1; p < 64; p++) begin
            logic [31:0] r;
            r = '0;
            for (int g = 0; g < 6; g++)
               if (p[g]) r[(g == 0) ? 0 : 4 + (g - 1) * 6 + 1] = 1'b1;
            step(r, 1'b0, 21'(k) << 19, "R6");
         end
      step(32'h0, 1'b0, 21'h1 << 19, "R6");
      step((32'h1 << 4) | (32'h1 << 10), 1'b0, 21'h1 << 19, "R6");
      expect_src(10, "R6");

      // R7: middle slot demoted
      zero_sel(21'h7F);
      step(32'h60, 1'b1, 21'h7F, "R7");
      expect_src(5, "R7");
      step(32'h60, 1'b0, 21'h7F, "R7");
      expect_src(6, "R7");

      // R8: slot 0 and slot 5 stay put
      zero_sel(21'h7F);
      step(32'h30, 1'b1, 21'h7F, "R8");
      expect_src(4, "R8");
      step(32'h30, 1'b0, 21'h7F, "R8");
      expect_src(4, "R8");
      step(32'h200, 1'b1, 21'h7F, "R8");
      expect_src(9, "R8");
      step(32'h60, 1'b0, 21'h7F, "R8");
      expect_src(5, "R8");

      // R9: rotation disabled
      zero_sel(21'h0);
      step(32'h60, 1'b1, 21'h0, "R9");
      expect_src(5, "R9");
      step(32'h60, 1'b0, 21'h0, "R9");
      expect_src(5, "R9");

      // R10: reload beats a same-cycle service pulse
      zero_sel(21'h7F);
      step(32'h60, 1'b1, 21'h7F | (21'h1 << 19), "R10");
      expect_src(5, "R10");
      step(32'h60, 1'b0, 21'h7F | (21'h1 << 19), "R10");
      expect_src(5, "R10");

      // R7 R10 R11: mixed pseudo-random traffic
      c = 21'h7F;
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] a, b;
         rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5; a = rs;
         rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5; b = rs;
         if (a[4:0] == 5'd0) c = b[20:0];
         step(a & b & {b[15:0], a[31:16]}, b[31], c, "R7 R10 R11");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule